// File: doc/BRIEF.md
# Circular Sample Buffer Pointer Controller

This block produces the write and read addresses for a byte-wide sample memory. Each converted sample is stored as two bytes. Both pointers move toward lower addresses. When the active pointer length is reached, they wrap. The host sets that length at run time with a thermometer-coded value. Loading that value zeroes both pointers.

A completed conversion causes two back-to-back write cycles, one for each byte lane. Each host read strobe moves the read pointer down by one byte. The fill level is the distance between the two pointers. The host can also:
- pull the write pointer back by two bytes with a strobe;
- clear both pointers with a strobe.

In streaming mode the block sets a held interrupt flag when the write pointer crosses a selected fill point. This applies whether the pointer was moved by conversions or by the host's step-back strobe. A mask input blocks new interrupts while the host adjusts the pointers. An acknowledge strobe clears the flag.

Top module: `sample_ptr_ctrl`

## Requirements
- R1: After reset, wr_addr, rd_addr and fill are 0, wr_en is 0, irq is 0 and irq_stat_n is 1.
- R2: A conv_done pulse taken while run is 1 and no write is in progress causes two write cycles. In the first cycle, wr_en=1, wr_lane=0 and wr_addr is the write pointer. In the second cycle, wr_en=1, wr_lane=1 and wr_addr is the write pointer minus one. The write pointer ends two lower than it started. A conv_done seen while run is 0, or during the second cycle, is ignored.
- R3: The active pointer width is 8 plus the number of ones in len_ctl. The legal values are 0x00 (8 bits), 0x01 (9), 0x03 (10), 0x07 (11), 0x0F (12), 0x1F (13), 0x3F (14) and 0x7F (15). Pointers wrap modulo 2^width. A len_wr pulse loads len_ctl and zeroes both pointers.
- R4: Each rd_strobe lowers the read pointer by one, with wrap. rd_addr always shows the read pointer.
- R5: fill equals (read pointer − write pointer) mod 2^width, and never exceeds 2^width − 1.
- R6: Each dec_w pulse lowers the write pointer by two, with wrap. If a write cycle happens in the same cycle, the two movements add.
- R7: A clr pulse zeroes both pointers.
- R8: irq_sel selects the interrupt event, based on the top two active bits of the write pointer:
  - 00: any change of the top bit (each half buffer);
  - 01: any change of the top two bits (each quarter buffer);
  - 10: the top bit going from 0 to 1 (wrap, each full buffer);
  - 11: completion of the second byte of each conversion.
- R9: A boundary crossing caused by dec_w raises the same interrupt as one caused by conversions.
- R10: An interrupt is raised only when fifo_mode is 1 and irq_mask is 0 in the cycle of the event.
- R11: The interrupt flag holds until an irq_ack pulse clears it. If an event and irq_ack occur in the same cycle, the flag is set. irq is active high and irq_stat_n is its active-low status (0 = pending).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Accept conversions when 1 |
| fifo_mode | input | 1 | Streaming mode; enables interrupts |
| conv_done | input | 1 | Conversion finished strobe |
| rd_strobe | input | 1 | Host has read one byte |
| len_wr | input | 1 | Load len_ctl and zero pointers |
| len_ctl | input | 7 | Thermometer-coded pointer length |
| irq_sel | input | 2 | Interrupt event select |
| irq_mask | input | 1 | Block new interrupts when 1 |
| dec_w | input | 1 | Step write pointer back by two |
| clr | input | 1 | Zero both pointers |
| irq_ack | input | 1 | Clear the pending interrupt |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | 15 | Memory write address |
| wr_lane | output | 1 | Byte lane of the current write |
| rd_addr | output | 15 | Memory read address |
| fill | output | 15 | Bytes held in the buffer |
| irq | output | 1 | Interrupt request |
| irq_stat_n | output | 1 | Interrupt status, 0 = pending |

## Verification
A write pointer that is off by one shows up at once on wr_addr, on the very next write cycle. It shows up in fill in the cycle after any pointer change. A wrong mask from the length register shows only at the first wrap: the address jumps to the wrong top value, or the half and quarter events move. The bench therefore walks pointers across every boundary using the step-back strobe. A wrongly decoded boundary appears on irq one cycle after the crossing step. It stays visible, because the flag holds until acknowledged.

// File: rtl/sample_ptr_ctrl.sv
module sample_ptr_ctrl #(
  parameter int BASE_W = 8,
  parameter int LEN_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    fifo_mode,
  input  logic                    conv_done,
  input  logic                    rd_strobe,
  input  logic                    len_wr,
  input  logic [LEN_W-1:0]        len_ctl,
  input  logic [1:0]              irq_sel,
  input  logic                    irq_mask,
  input  logic                    dec_w,
  input  logic                    clr,
  input  logic                    irq_ack,
  output logic                    wr_en,
  output logic [BASE_W+LEN_W-1:0] wr_addr,
  output logic                    wr_lane,
  output logic [BASE_W+LEN_W-1:0] rd_addr,
  output logic [BASE_W+LEN_W-1:0] fill,
  output logic                    irq,
  output logic                    irq_stat_n
);
  localparam int AW = BASE_W + LEN_W;
  localparam int CW = $clog2(AW + 1);

  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]    ptr_mask, wptr, rptr, wptr_nxt, rptr_nxt, step, sh_old, sh_new;
  logic [CW-1:0]    act_w;
  logic [1:0]       q_old, q_new;
  logic             phase, start, pend, evt, set_irq, reload;

  assign ptr_mask = {len_q, {BASE_W{1'b1}}};

  always_comb begin
    act_w = CW'(BASE_W);
    for (int i = 0; i < LEN_W; i++) act_w = act_w + CW'(len_q[i]);
  end

  assign start   = conv_done && run && !phase;
  assign wr_en   = start || phase;
  assign wr_lane = phase;
  assign wr_addr = wptr;
  assign rd_addr = rptr;
  assign fill    = (rptr - wptr) & ptr_mask;
  assign reload  = clr || len_wr;

  assign step     = {{(AW-1){1'b0}}, wr_en} + (dec_w ? AW'(2) : '0);
  assign wptr_nxt = (wptr - step) & ptr_mask;
  assign rptr_nxt = (rptr - {{(AW-1){1'b0}}, rd_strobe}) & ptr_mask;

  assign sh_old = wptr >> (act_w - CW'(2));
  assign sh_new = wptr_nxt >> (act_w - CW'(2));
  assign q_old  = sh_old[1:0];
  assign q_new  = sh_new[1:0];

  always_comb begin
    case (irq_sel)
      2'b00:   evt = q_old[1] != q_new[1];
      2'b01:   evt = q_old != q_new;
      2'b10:   evt = !q_old[1] && q_new[1];
      default: evt = phase;
    endcase
  end

  assign set_irq    = evt && fifo_mode && !irq_mask && !reload;
  assign irq        = pend;
  assign irq_stat_n = !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      phase <= 1'b0;
      pend  <= 1'b0;
    end else begin
      phase <= start;
      if (len_wr) begin
        len_q <= len_ctl;
        wptr  <= '0;
        rptr  <= '0;
      end else if (clr) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        wptr <= wptr_nxt;
        rptr <= rptr_nxt;
      end
      if (set_irq)      pend <= 1'b1;
      else if (irq_ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_ptr_chk.sv
module sample_ptr_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic          rd_strobe,
  input logic          len_wr,
  input logic          irq_mask,
  input logic          dec_w,
  input logic          clr,
  input logic          irq_ack,
  input logic          wr_en,
  input logic          wr_lane,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] fill,
  input logic [AW-1:0] ptr_mask,
  input logic          irq
);
  assert_lane_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_lane |=> wr_en && wr_lane);

  assert_len_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr |=> rd_addr == '0 && wr_addr == '0);

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ptr_mask);

  assert_dec_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_w && !wr_en && !rd_strobe && !clr && !len_wr
    |=> fill == (($past(fill) + AW'(2)) & $past(ptr_mask)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !len_wr |=> rd_addr == '0 && wr_addr == '0 && fill == '0);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fifo_mode) && !$past(irq_mask));

  assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !fifo_mode |=> !irq);
endmodule

bind sample_ptr_ctrl sample_ptr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rd_strobe(rd_strobe),
  .len_wr(len_wr), .irq_mask(irq_mask), .dec_w(dec_w), .clr(clr),
  .irq_ack(irq_ack), .wr_en(wr_en), .wr_lane(wr_lane), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .fill(fill), .ptr_mask(ptr_mask), .irq(irq)
);

// File: tb/sim_sample_ptr_ctrl.sv
module sim_sample_ptr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, fifo_mode = 1'b0, conv_done = 1'b0, rd_strobe = 1'b0;
  logic        len_wr = 1'b0, irq_mask = 1'b0, dec_w = 1'b0, clr = 1'b0, irq_ack = 1'b0;
  logic [6:0]  len_ctl = 7'h00;
  logic [1:0]  irq_sel = 2'b00;
  logic        wr_en, wr_lane, irq, irq_stat_n;
  logic [14:0] wr_addr, rd_addr, fill;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sample_ptr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .fifo_mode(fifo_mode), .conv_done(conv_done),
    .rd_strobe(rd_strobe), .len_wr(len_wr), .len_ctl(len_ctl), .irq_sel(irq_sel),
    .irq_mask(irq_mask), .dec_w(dec_w), .clr(clr), .irq_ack(irq_ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane(wr_lane), .rd_addr(rd_addr),
    .fill(fill), .irq(irq), .irq_stat_n(irq_stat_n)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic pulse_dec();
    dec_w = 1'b1; tick(); dec_w = 1'b0;
  endtask

  task automatic load_len(input logic [6:0] v);
    len_ctl = v; len_wr = 1'b1; tick(); len_wr = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 rd_addr", rd_addr, 0);
    chk("R1 fill", fill, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 irq", irq, 0);
    chk("R1 irq_stat_n", irq_stat_n, 1);
  endtask

  task automatic t_conversion();
    pulse_clr(); run = 1'b1;
    conv_done = 1'b1; #1;
    chk("R2 first wr_en", wr_en, 1);
    chk("R2 first lane", wr_lane, 0);
    chk("R2 first addr", wr_addr, 0);
    tick(); conv_done = 1'b0; #1;
    chk("R2 second wr_en", wr_en, 1);
    chk("R2 second lane", wr_lane, 1);
    chk("R2 second addr wrap R3", wr_addr, 'hFF);
    tick();
    chk("R2 idle after pair", wr_en, 0);
    chk("R5 fill after one sample", fill, 2);
    run = 1'b0; conv_done = 1'b1; #1;
    chk("R2 run low no write", wr_en, 0);
    tick(); conv_done = 1'b0; tick();
    chk("R2 run low fill kept", fill, 2);
    run = 1'b1; conv_done = 1'b1; tick(); tick(); conv_done = 1'b0; #1;
    chk("R2 held strobe single pair", wr_en, 0);
    chk("R2 held strobe fill", fill, 4);
  endtask

  task automatic t_read();
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
    chk("R4 rd_addr wrap", rd_addr, 'hFF);
    chk("R5 fill after read", fill, 3);
  endtask

  task automatic t_clear();
    pulse_clr();
    chk("R7 rd_addr", rd_addr, 0);
    chk("R7 wr_addr", wr_addr, 0);
    chk("R7 fill", fill, 0);
  endtask

  task automatic t_length();
    pulse_dec();
    load_len(7'h01);
    chk("R3 len load zeroes wr", wr_addr, 0);
    chk("R3 len load zeroes fill", fill, 0);
    conv_done = 1'b1; tick(); conv_done = 1'b0; #1;
    chk("R3 9-bit wrap addr", wr_addr, 'h1FF);
    tick();
    chk("R3 9-bit fill", fill, 2);
    load_len(7'h7F);
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
    chk("R3 R4 15-bit read wrap", rd_addr, 'h7FFF);
    chk("R5 15-bit fill", fill, 'h7FFF);
    load_len(7'h00);
  endtask

  task automatic t_dec();
    pulse_clr(); pulse_dec();
    chk("R6 dec wr_addr", wr_addr, 'hFE);
    chk("R6 dec fill", fill, 2);
  endtask

  task automatic t_irq_half();
    fifo_mode = 1'b1; irq_sel = 2'b00; pulse_clr(); pulse_ack();
    pulse_dec();
    chk("R8 R9 half at wrap", irq, 1);
    pulse_ack();
    for (int i = 0; i < 63; i++) pulse_dec();
    chk("R8 half not yet", irq, 0);
    pulse_dec();
    chk("R8 R9 half crossing", irq, 1);
    chk("R11 stat_n pending", irq_stat_n, 0);
    tick();
    chk("R11 held", irq, 1);
    pulse_ack();
    chk("R11 ack clears", irq, 0);
    chk("R11 stat_n clear", irq_stat_n, 1);
  endtask

  task automatic t_irq_quarter();
    irq_sel = 2'b01; pulse_clr(); pulse_dec(); pulse_ack();
    for (int i = 0; i < 31; i++) pulse_dec();
    chk("R8 quarter not yet", irq, 0);
    pulse_dec();
    chk("R8 R9 quarter crossing", irq, 1);
    pulse_ack();
  endtask

  task automatic t_irq_full();
    irq_sel = 2'b10; pulse_clr(); pulse_dec();
    chk("R8 full at wrap", irq, 1);
    pulse_ack();
    for (int i = 0; i < 127; i++) pulse_dec();
    chk("R8 full ignores half", irq, 0);
    pulse_dec();
    chk("R8 full second wrap", irq, 1);
    pulse_ack();
  endtask

  task automatic t_irq_conv();
    irq_sel = 2'b11; pulse_clr();
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    chk("R8 conv not after first byte", irq, 0);
    tick();
    chk("R8 conv after second byte", irq, 1);
    pulse_ack();
    conv_done = 1'b1; tick(); conv_done = 1'b0; irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk("R11 set wins over ack", irq, 1);
    pulse_ack();
  endtask

  task automatic t_irq_gate();
    irq_sel = 2'b00; pulse_clr();
    irq_mask = 1'b1; pulse_dec(); irq_mask = 1'b0;
    chk("R10 mask blocks", irq, 0);
    fifo_mode = 1'b0; pulse_clr(); pulse_dec();
    chk("R10 burst no irq", irq, 0);
    fifo_mode = 1'b1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    tick(); tick(); rst_n = 1'b1; tick();
    t_reset();
    t_conversion();
    t_read();
    t_clear();
    t_length();
    t_dec();
    t_irq_half();
    t_irq_quarter();
    t_irq_full();
    t_irq_conv();
    t_irq_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule